// File: doc/BRIEF.md
# Two-Way Late-Select Synchronous SRAM

This block is a synchronous memory front end that keeps two ways of a byte-lane-organised data word behind one shared index. On a read the index is captured at one rising clock edge. The way-select bit is captured at the following edge. Both ways are therefore read in parallel during the cycle in between, and the late bit picks which of the two candidate words reaches the output register. A cache controller can use this to issue the set index before its tag compare has decided which way hit.

Writes use late-write timing. The index, the way bit and the active-low byte enables are all sampled at the same edge, and the data word follows at the next edge. The most recent write is held in a single-entry buffer. It is placed into the array only when the data of the following write arrives. Each way compares its read index against the buffer on its own, and the late way bit chooses which of those merged results is returned, so a read always sees the newest data. An asynchronous active-low output enable gates the drive indication of the read data.

Top module: `twoway_late_sram`

## Requirements
- R1: After reset `dq_drive` is low, `rdata` is all zeros and no write is pending.
- R2: An edge with `sel_n` low and `wr_n` high starts a read of index `idx`. At the next edge `rdata` is loaded with the word of the way given by `late_way` at that edge (0 selects way 0, 1 selects way 1).
- R3: `dq_drive` is high only in the cycle that follows a read's second edge. After a deselect or a write it is low in the corresponding cycle.
- R4: The `late_way` value sampled at a read's second edge is used even when `sel_n` is high at that edge.
- R5: An edge with `sel_n` low and `wr_n` low samples `idx`, `late_way` and `be_n` together. The matching `wdata` is taken at the next edge.
- R6: A read whose way and index match the buffered write returns the buffered bytes in the enabled lanes and the array bytes in the other lanes. The match is evaluated per way, and the late way bit selects the result, so a read of the other way at the same index is unaffected.
- R7: A buffered write moves into the array when the next write's data arrives. Later reads of that location return the written data.
- R8: `be_n[i]` low enables lane i, bits [9i+8:9i], for writing. A write with all bits of `be_n` high changes no stored bit.
- R9: `oe_n` acts without a clock. `dq_drive` equals the internal read-valid state ANDed with `oe_n` low, within the same cycle.
- R10: `rdata` keeps its value in every cycle in which no read completes.
- R11: Reads issued at consecutive edges each return their word one edge after their way bit, giving one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select, sampled at the edge |
| wr_n | input | 1 | Active-low write enable, sampled at the edge |
| be_n | input | LANES | Active-low byte-lane write enables, sampled with the write address |
| idx | input | IDX_W | Shared index address |
| late_way | input | 1 | Way-select bit: second read edge, or together with the write address |
| wdata | input | LANES*LANE_W | Write data, one edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Output register holding the read word |
| dq_drive | output | 1 | High while the read data is driven |

## Verification
A stale or wrongly merged write buffer shows up as a wrong lane in `rdata` in the cycle after the second edge of the first read of that way and index. A buffer that is committed too early or to the wrong way shows up only on a later read of the untouched way, or after the next write. A late-select mux that latches the wrong edge's way bit swaps the two ways' words in the same cycle. An output stage that reloads outside a read breaks the hold of `rdata` at the next idle edge. The bench's reference model keeps a flat image of each location that is updated as soon as the data arrives, so every one of these faults is visible as a mismatch on the first affected cycle.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } lsram_op_e;

   localparam int unsigned LSRAM_WAYS = 2;

endpackage

// File: rtl/lsram_way_bank.sv
module lsram_way_bank #(
   parameter int IDX_W  = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [LANES-1:0]          wr_lane_en,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]          rd_idx,
   output logic [LANES*LANE_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_lane_en[l])
            store[wr_idx] <= wr_data[l*LANE_W +: LANE_W];
      end

      assign rd_data[l*LANE_W +: LANE_W] = store[rd_idx];
   end
endmodule

// File: rtl/lsram_wbuf.sv
module lsram_wbuf #(
   parameter int IDX_W  = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic [IDX_W-1:0]                ld_idx,
   input  logic                            ld_way,
   input  logic [LANES-1:0]                ld_lane_en,
   input  logic [LANES*LANE_W-1:0]         ld_data,
   input  logic [IDX_W-1:0]                rd_idx,
   input  logic [1:0][LANES*LANE_W-1:0]    arr_data,
   output logic [1:0][LANES*LANE_W-1:0]    merged,
   output logic                            commit_en,
   output logic                            commit_way,
   output logic [IDX_W-1:0]                commit_idx,
   output logic [LANES-1:0]                commit_lane_en,
   output logic [LANES*LANE_W-1:0]         commit_data
);
   localparam int DATA_W = LANES * LANE_W;

   logic              buf_valid;
   logic [IDX_W-1:0]  buf_idx;
   logic              buf_way;
   logic [LANES-1:0]  buf_lane_en;
   logic [DATA_W-1:0] buf_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_valid   <= 1'b0;
         buf_idx     <= '0;
         buf_way     <= 1'b0;
         buf_lane_en <= '0;
         buf_data    <= '0;
      end else if (load) begin
         buf_valid   <= 1'b1;
         buf_idx     <= ld_idx;
         buf_way     <= ld_way;
         buf_lane_en <= ld_lane_en;
         buf_data    <= ld_data;
      end
   end

   // the old entry retires into the array on the edge that brings new data
   assign commit_en      = load && buf_valid;
   assign commit_way     = buf_way;
   assign commit_idx     = buf_idx;
   assign commit_lane_en = buf_lane_en;
   assign commit_data    = buf_data;

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic hit;
      assign hit = buf_valid && (buf_idx == rd_idx) && (buf_way == 1'(w));
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign merged[w][l*LANE_W +: LANE_W] =
            (hit && buf_lane_en[l]) ? buf_data[l*LANE_W +: LANE_W]
                                    : arr_data[w][l*LANE_W +: LANE_W];
      end
   end

   // R7: a loaded entry stays present
   assert_entry_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> buf_valid);

   // R6: the compared location only changes when new write data arrives
   assert_entry_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !load) |=> ($stable(buf_idx) && $stable(buf_way) && $stable(buf_data)));
endmodule

// File: rtl/lsram_outstage.sv
module lsram_outstage #(
   parameter int DATA_W       = 36,
   parameter int MUX_AT_DRIVE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    way,
   input  logic [1:0][DATA_W-1:0]  cand,
   output logic [DATA_W-1:0]       out
);
   if (MUX_AT_DRIVE == 0) begin : g_mux_first
      logic [DATA_W-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    out_q <= '0;
         else if (load) out_q <= way ? cand[1] : cand[0];
      end
      assign out = out_q;
   end else begin : g_mux_late
      // both halves and the select are registered; select settles with the data
      logic [1:0][DATA_W-1:0] half_q;
      logic                   way_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_q <= '0;
            way_q  <= 1'b0;
         end else if (load) begin
            half_q <= cand;
            way_q  <= way;
         end
      end
      assign out = way_q ? half_q[1] : half_q[0];
   end

   // R10: output holds when no read completes
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(out));
endmodule

// File: rtl/twoway_late_sram.sv
module twoway_late_sram
   import lsram_pkg::*;
#(
   parameter int IDX_W        = 4,
   parameter int LANES        = 4,
   parameter int LANE_W       = 9,
   parameter int MUX_AT_DRIVE = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_n,
   input  logic                     wr_n,
   input  logic [LANES-1:0]         be_n,
   input  logic [IDX_W-1:0]         idx,
   input  logic                     late_way,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic                     oe_n,
   output logic [LANES*LANE_W-1:0]  rdata,
   output logic                     dq_drive
);
   localparam int DATA_W = LANES * LANE_W;

   if (IDX_W < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_size
      $error("twoway_late_sram: sizes must be positive");
   end
   if (MUX_AT_DRIVE != 0 && MUX_AT_DRIVE != 1) begin : g_bad_variant
      $error("twoway_late_sram: MUX_AT_DRIVE must be 0 or 1");
   end

   lsram_op_e op;
   always_comb begin
      if (sel_n)     op = OP_IDLE;
      else if (wr_n) op = OP_READ;
      else           op = OP_WRITE;
   end

   logic             rd_pend, out_valid, wr_pend, wr_way_q;
   logic [IDX_W-1:0] rd_idx_q, wr_idx_q;
   logic [LANES-1:0] wr_be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend   <= 1'b0;
         out_valid <= 1'b0;
         wr_pend   <= 1'b0;
         rd_idx_q  <= '0;
         wr_idx_q  <= '0;
         wr_way_q  <= 1'b0;
         wr_be_q   <= '1;
      end else begin
         rd_pend   <= (op == OP_READ);
         wr_pend   <= (op == OP_WRITE);
         out_valid <= rd_pend;
         if (op == OP_READ) rd_idx_q <= idx;
         if (op == OP_WRITE) begin
            wr_idx_q <= idx;
            wr_way_q <= late_way;
            wr_be_q  <= be_n;
         end
      end
   end

   logic [1:0][DATA_W-1:0] arr_data, merged;
   logic                   commit_en, commit_way;
   logic [IDX_W-1:0]       commit_idx;
   logic [LANES-1:0]       commit_lane_en;
   logic [DATA_W-1:0]      commit_data;

   lsram_wbuf #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
      .clk            (clk),
      .rst_n          (rst_n),
      .load           (wr_pend),
      .ld_idx         (wr_idx_q),
      .ld_way         (wr_way_q),
      .ld_lane_en     (~wr_be_q),
      .ld_data        (wdata),
      .rd_idx         (rd_idx_q),
      .arr_data       (arr_data),
      .merged         (merged),
      .commit_en      (commit_en),
      .commit_way     (commit_way),
      .commit_idx     (commit_idx),
      .commit_lane_en (commit_lane_en),
      .commit_data    (commit_data)
   );

   for (genvar w = 0; w < int'(LSRAM_WAYS); w++) begin : g_bank
      lsram_way_bank #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
         .clk        (clk),
         .wr_en      (commit_en && (commit_way == 1'(w))),
         .wr_idx     (commit_idx),
         .wr_lane_en (commit_lane_en),
         .wr_data    (commit_data),
         .rd_idx     (rd_idx_q),
         .rd_data    (arr_data[w])
      );
   end

   lsram_outstage #(.DATA_W(DATA_W), .MUX_AT_DRIVE(MUX_AT_DRIVE)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_pend),
      .way   (late_way),
      .cand  (merged),
      .out   (rdata)
   );

   assign dq_drive = out_valid && !oe_n;

   // R3: data is driven only two edges after a read was issued
   assert_drive_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(op == OP_READ, 2));

   // R5: write data is taken only after a sampled write address
   assert_data_after_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend |-> ($past(!sel_n) && $past(!wr_n)));
endmodule

// File: tb/sim_twoway_late_sram.sv
module sim_twoway_late_sram;
   localparam int IW = 4;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1, wr_n = 1'b1, late_way = 1'b0, oe_n = 1'b0;
   logic [NL-1:0] be_n = '1;
   logic [IW-1:0] idx = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          dq_drive;

   always #4 clk = ~clk;

   twoway_late_sram #(.IDX_W(IW), .LANES(NL), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .be_n(be_n),
      .idx(idx), .late_way(late_way), .wdata(wdata), .oe_n(oe_n),
      .rdata(rdata), .dq_drive(dq_drive)
   );

   int    checks = 0, fails = 0;
   bit    done = 0;
   string req = "R1";

   // reference: flat image of each location, updated when data arrives
   logic [DW-1:0] img [2][1<<IW];
   logic          m_rd = 0, m_wr = 0, m_wway = 0, exp_valid = 0;
   logic [IW-1:0] m_ridx = '0, m_widx = '0;
   logic [NL-1:0] m_wbe = '1;
   logic [DW-1:0] exp_hold = '0, carry = '0;

   function automatic logic [DW-1:0] pat(int w, int i, int salt);
      return {4'(w + 1), 4'(i), 28'h5A3C0F1 ^ 28'(i * 977 + salt * 31)};
   endfunction

   task automatic check(logic [DW-1:0] got, logic [DW-1:0] exp, string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // one clock: s/w active-low, i index, wy way bit, nd = data for this op if write
   task automatic step(logic s, logic w, logic [NL-1:0] be, logic [IW-1:0] i,
                       logic wy, logic [DW-1:0] nd, logic oe);
      logic [DW-1:0] d_now;
      @(negedge clk);
      d_now = carry;
      sel_n = s; wr_n = w; be_n = be; idx = i; late_way = wy; oe_n = oe;
      wdata = d_now;
      carry = nd;
      @(posedge clk);
      exp_valid = m_rd;
      if (m_rd) exp_hold = img[wy][m_ridx];
      if (m_wr)
         for (int l = 0; l < NL; l++)
            if (!m_wbe[l]) img[m_wway][m_widx][l*LW +: LW] = d_now[l*LW +: LW];
      m_rd = !s && w;
      m_wr = !s && !w;
      if (!s && w) m_ridx = i;
      if (!s && !w) begin m_widx = i; m_wway = wy; m_wbe = be; end
      #1;
      check({{(DW-1){1'b0}}, dq_drive}, {{(DW-1){1'b0}}, exp_valid && !oe}, "dq_drive");
      check(rdata, exp_hold, "rdata");
   endtask

   task automatic wr(logic [IW-1:0] i, logic wy, logic [NL-1:0] be, logic [DW-1:0] d);
      step(1'b0, 1'b0, be, i, wy, d, 1'b0);
   endtask
   task automatic rd(logic [IW-1:0] i, logic wy_prev);
      step(1'b0, 1'b1, '1, i, wy_prev, '0, 1'b0);
   endtask
   task automatic idle(logic wy);
      step(1'b1, 1'b1, '1, '0, wy, '0, 1'b0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL %s watchdog expired: got hang expected completion", req);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < 2; w++)
         for (int i = 0; i < (1<<IW); i++) img[w][i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      req = "R1";
      check({{(DW-1){1'b0}}, dq_drive}, '0, "dq_drive after reset");
      check(rdata, '0, "rdata after reset");
      idle(1'b0);

      // R5 R7: fill every location of both ways with full-lane writes
      req = "R5";
      for (int w = 0; w < 2; w++)
         for (int i = 0; i < (1<<IW); i++)
            wr(4'(i), 1'(w), '0, pat(w, i, 0));
      idle(1'b0);

      // R2: single reads, way chosen at the second edge
      req = "R2";
      rd(4'd2, 1'b0); idle(1'b1); idle(1'b0);
      rd(4'd7, 1'b0); idle(1'b0); idle(1'b0);

      // R11: back-to-back reads, way bit of each arrives with the next index
      req = "R11";
      rd(4'd1, 1'b0);
      rd(4'd5, 1'b1);
      rd(4'd9, 1'b0);
      rd(4'd14, 1'b1);
      idle(1'b1); idle(1'b0);

      // R4: second edge deselected but its way bit still selects
      req = "R4";
      rd(4'd3, 1'b0); idle(1'b1);
      rd(4'd3, 1'b0); idle(1'b0);
      idle(1'b0);

      // R6: partial write left in buffer, then reads of both ways at that index
      req = "R6";
      wr(4'd6, 1'b1, 4'b1010, 36'hABC_DEF_123);
      rd(4'd6, 1'b0);
      rd(4'd6, 1'b1);
      rd(4'd6, 1'b0);
      idle(1'b1);
      // R3: write right after read completes -> not driven
      req = "R3";
      rd(4'd4, 1'b0);
      wr(4'd11, 1'b0, 4'b0000, pat(0, 11, 5));
      idle(1'b0);
      idle(1'b0);

      // R7: the buffered entry retires; array now holds both writes
      req = "R7";
      wr(4'd12, 1'b0, 4'b0110, 36'h123_456_789);
      idle(1'b0);
      rd(4'd6, 1'b0); idle(1'b1);
      rd(4'd11, 1'b0); idle(1'b0);
      rd(4'd12, 1'b0); idle(1'b0);

      // R8: lane enables all high -> no change, then single lane 3
      req = "R8";
      wr(4'd12, 1'b0, 4'b1111, '1);
      wr(4'd0, 1'b1, 4'b0111, 36'hFFF_000_000);
      idle(1'b0);
      rd(4'd12, 1'b0); idle(1'b0);
      rd(4'd0, 1'b0); idle(1'b1);
      wr(4'd2, 1'b0, 4'b1111, '0);
      idle(1'b0);
      rd(4'd0, 1'b0); idle(1'b1);
      rd(4'd12, 1'b0); idle(1'b0);

      // R9: output enable high blocks drive; async toggle inside a cycle
      req = "R9";
      rd(4'd8, 1'b0);
      step(1'b1, 1'b1, '1, '0, 1'b1, '0, 1'b1);
      rd(4'd8, 1'b0);
      idle(1'b0);
      oe_n = 1'b1; #1;
      check({{(DW-1){1'b0}}, dq_drive}, '0, "dq_drive with oe_n high");
      oe_n = 1'b0; #1;
      check({{(DW-1){1'b0}}, dq_drive}, {{(DW-1){1'b0}}, 1'b1}, "dq_drive with oe_n low");

      // R10: idle cycles hold the last word
      req = "R10";
      idle(1'b1); idle(1'b0); idle(1'b1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule